// File: doc/BRIEF.md
# Security Fuse Burn Sequencer

This block guards the burning of two one-time security fuses. Software reaches it through a byte-wide register write port that decodes two addresses: a fuse-control register and a trim-control register. A burn can start only after an exact write series. First an unlock key goes to the fuse-control register. Next a mode code goes to the same register and names the one fuse to burn. Last a trigger value goes to the trim-control register. The block then raises a burn-enable together with a one-hot fuse select, which drive the analog programming circuit. Software ends the burn by writing zero to the trim-control register after roughly 500 µs. A hardware limit ends the burn anyway if software never does.

Burning the mode-1 fuse needs the external security pin to be high, both when mode 1 is selected and for as long as the burn runs. Burning the mode-0 fuse ignores the pin. A read-only status byte shows the synchronised pin level, the two fuse states and a sticky error flag. The flag is set when the mode-1 code arrives while the pin is low, and it clears when software reads the status.

Top module: `fuse_burn_seq`

## Requirements
- R1: After reset, burnEn is 0, fuseSel is 00 and the error flag (stsData bit 7) is 0.
- R2: Writing 0x54 to the fuse-control address (2) arms key entry. A following fuse-control write of 0x81 then sets fuseSel to 01 (mode 0), and 0x82 sets it to 10 (mode 1). The select is visible the cycle after the write.
- R3: With a fuse selected, writing 0xA6 to the trim-control address (1) raises burnEn from the next cycle on. Writing 0x00 there during the burn drops burnEn and clears fuseSel.
- R4: Any write that breaks the order sends the sequencer back to idle, and the key must be written again. This covers a wrong value, a trim-control write before a fuse is selected, a fuse-control write after selection, and a nonzero trim-control write during a burn.
- R5: Writes to any address other than 1 and 2 are ignored and do not disturb the sequence.
- R6: Mode 1 is accepted only while the synchronised pin is high. If the pin goes low while mode 1 is selected or burning, the sequencer aborts to idle.
- R7: Writing the mode-1 code while the pin is low aborts the sequence and sets stsData bit 7. A one-cycle pulse on stsRd clears that bit.
- R8: A burn that software does not end lasts exactly MAX_BURN_CYCLES cycles. After that, burnEn and fuseSel return to 0.
- R9: stsData bit 5 shows the security pin after a two-flop synchroniser. Bit 1 shows the mode-0 fuse state and bit 2 shows the mode-1 fuse state. All other bits except bit 7 read 0.
- R10: While burnEn is high, exactly one bit of fuseSel is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | 8 | Register write data |
| stsRd | input | 1 | Status read strobe; clears the error flag |
| secPin | input | 1 | External security pin (asynchronous) |
| fuse0Blown | input | 1 | Mode-0 fuse state |
| fuse1Blown | input | 1 | Mode-1 fuse state |
| stsData | output | 8 | Status byte |
| burnEn | output | 1 | Fuse burn enable |
| fuseSel | output | 2 | One-hot fuse select (bit 0 mode 0, bit 1 mode 1) |

## Verification
Two situations are the hardest to reach from the ports. One is the hardware time limit, because it needs a full sequence and then a deliberate silence from software. The other is losing the pin in the middle of a mode-1 burn, because the pin passes through a synchroniser and the burn must already be running. The bench runs the complete key, select and trigger series, then counts the cycles burnEn stays high with no stop write. In a separate run it drops the pin partway through an active mode-1 burn and waits out the synchroniser before checking for the abort. The error flag is reached by offering the mode-1 code with the pin held low for several cycles beforehand.

// File: rtl/fuse_burn_pkg.sv
package fuse_burn_pkg;
  localparam logic [7:0] KEY_CODE  = 8'h54;
  localparam logic [7:0] SEL0_CODE = 8'h81;
  localparam logic [7:0] SEL1_CODE = 8'h82;
  localparam logic [7:0] TRIG_CODE = 8'hA6;
  localparam logic [7:0] STOP_CODE = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEYED, ST_ARMED0, ST_ARMED1, ST_BURN0, ST_BURN1
  } seq_state_t;

  // decoded bus and datapath conditions for the control
  typedef struct packed {
    logic fuseWr;
    logic trimWr;
    logic keyVal;
    logic sel0Val;
    logic sel1Val;
    logic trigVal;
    logic pinHigh;
    logic timeout;
  } dp_flags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic burnRun;
    logic setErr;
  } ctrl_strobes_t;
endpackage

// File: rtl/fuse_burn_datapath.sv
module fuse_burn_datapath
  import fuse_burn_pkg::*;
#(
  parameter int ADDR_W          = 2,
  parameter int FUSE_ADDR       = 2,
  parameter int TRIM_ADDR       = 1,
  parameter int MAX_BURN_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              stsRd,
  input  logic              secPin,
  input  logic              fuse0Blown,
  input  logic              fuse1Blown,
  input  ctrl_strobes_t     strobes,
  output dp_flags_t         flags,
  output logic [7:0]        stsData
);
  localparam int CNT_W = $clog2(MAX_BURN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_BURN_CYCLES - 1);
  localparam logic [ADDR_W-1:0] FUSE_A = ADDR_W'(FUSE_ADDR);
  localparam logic [ADDR_W-1:0] TRIM_A = ADDR_W'(TRIM_ADDR);

  logic [1:0]       pinPipe;
  logic [CNT_W-1:0] burnCnt;
  logic             errSticky;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPipe <= 2'b00;
    else       pinPipe <= {pinPipe[0], secPin};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               burnCnt <= '0;
    else if (strobes.burnRun) burnCnt <= burnCnt + 1'b1;
    else                     burnCnt <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               errSticky <= 1'b0;
    else if (strobes.setErr) errSticky <= 1'b1;
    else if (stsRd)          errSticky <= 1'b0;
  end

  always_comb begin
    flags.fuseWr  = wrEn && (wrAddr == FUSE_A);
    flags.trimWr  = wrEn && (wrAddr == TRIM_A);
    flags.keyVal  = (wrData == KEY_CODE);
    flags.sel0Val = (wrData == SEL0_CODE);
    flags.sel1Val = (wrData == SEL1_CODE);
    flags.trigVal = (wrData == TRIG_CODE);
    flags.pinHigh = pinPipe[1];
    flags.timeout = strobes.burnRun && (burnCnt == CNT_LAST);
  end

  assign stsData = {errSticky, 1'b0, pinPipe[1], 2'b00, fuse1Blown, fuse0Blown, 1'b0};
endmodule

// File: rtl/fuse_burn_ctrl.sv
module fuse_burn_ctrl
  import fuse_burn_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  dp_flags_t     flags,
  output ctrl_strobes_t strobes,
  output logic          burnEn,
  output logic [1:0]    fuseSel
);
  seq_state_t state, nextState;

  always_comb begin
    nextState      = state;
    strobes.setErr = 1'b0;
    case (state)
      ST_IDLE:
        if (flags.fuseWr && flags.keyVal) nextState = ST_KEYED;
      ST_KEYED:
        if (flags.fuseWr) begin
          if (flags.sel0Val)                        nextState = ST_ARMED0;
          else if (flags.sel1Val && flags.pinHigh)  nextState = ST_ARMED1;
          else begin
            nextState      = ST_IDLE;
            strobes.setErr = flags.sel1Val;
          end
        end else if (flags.trimWr) nextState = ST_IDLE;
      ST_ARMED0:
        if (flags.fuseWr)      nextState = ST_IDLE;
        else if (flags.trimWr) nextState = flags.trigVal ? ST_BURN0 : ST_IDLE;
      ST_ARMED1:
        if (!flags.pinHigh || flags.fuseWr) nextState = ST_IDLE;
        else if (flags.trimWr)              nextState = flags.trigVal ? ST_BURN1 : ST_IDLE;
      ST_BURN0:
        if (flags.fuseWr || flags.trimWr || flags.timeout) nextState = ST_IDLE;
      ST_BURN1:
        if (flags.fuseWr || flags.trimWr || flags.timeout || !flags.pinHigh)
          nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign strobes.burnRun = (state == ST_BURN0) || (state == ST_BURN1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      burnEn  <= 1'b0;
      fuseSel <= 2'b00;
    end else begin
      state      <= nextState;
      burnEn     <= (nextState == ST_BURN0) || (nextState == ST_BURN1);
      fuseSel[0] <= (nextState == ST_ARMED0) || (nextState == ST_BURN0);
      fuseSel[1] <= (nextState == ST_ARMED1) || (nextState == ST_BURN1);
    end
  end
endmodule

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq
  import fuse_burn_pkg::*;
#(
  parameter int ADDR_W          = 2,
  parameter int FUSE_ADDR       = 2,
  parameter int TRIM_ADDR       = 1,
  parameter int MAX_BURN_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              stsRd,
  input  logic              secPin,
  input  logic              fuse0Blown,
  input  logic              fuse1Blown,
  output logic [7:0]        stsData,
  output logic              burnEn,
  output logic [1:0]        fuseSel
);
  dp_flags_t     flags;
  ctrl_strobes_t strobes;

  fuse_burn_datapath #(
    .ADDR_W(ADDR_W), .FUSE_ADDR(FUSE_ADDR), .TRIM_ADDR(TRIM_ADDR),
    .MAX_BURN_CYCLES(MAX_BURN_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stsRd(stsRd), .secPin(secPin), .fuse0Blown(fuse0Blown),
    .fuse1Blown(fuse1Blown), .strobes(strobes), .flags(flags), .stsData(stsData)
  );

  fuse_burn_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .flags(flags), .strobes(strobes),
    .burnEn(burnEn), .fuseSel(fuseSel)
  );
endmodule

// File: rtl/fuse_burn_seq_checker.sv
module fuse_burn_seq_checker #(
  parameter int ADDR_W          = 2,
  parameter int FUSE_ADDR       = 2,
  parameter int TRIM_ADDR       = 1,
  parameter int MAX_BURN_CYCLES = 50000
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic [7:0]        stsData,
  input logic              burnEn,
  input logic [1:0]        fuseSel
);
  localparam int CW = $clog2(MAX_BURN_CYCLES + 1) + 1;
  logic [CW-1:0] burnRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       burnRun <= '0;
    else if (burnEn) burnRun <= burnRun + 1'b1;
    else             burnRun <= '0;
  end

  assert_burn_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    burnEn |-> ($countones(fuseSel) == 1));

  assert_trigger_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(burnEn) |-> $past(wrEn && (wrAddr == ADDR_W'(TRIM_ADDR)) && (wrData == 8'hA6)));

  assert_pin_mode1_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fuseSel[1] && !$past(rstN == 1'b0)) |-> $past(stsData[5]));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsData[7]) |-> $past(wrEn && (wrAddr == ADDR_W'(FUSE_ADDR)) &&
                                (wrData == 8'h82) && !stsData[5]));

  assert_burn_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    burnEn |-> (burnRun < CW'(MAX_BURN_CYCLES)));

  assert_sel_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(burnEn) |-> (fuseSel == 2'b00));
endmodule

bind fuse_burn_seq fuse_burn_seq_checker #(
  .ADDR_W(ADDR_W), .FUSE_ADDR(FUSE_ADDR), .TRIM_ADDR(TRIM_ADDR),
  .MAX_BURN_CYCLES(MAX_BURN_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .stsData(stsData), .burnEn(burnEn), .fuseSel(fuseSel)
);

// File: tb/fuse_burn_seq_test.sv
module fuse_burn_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_BURN   = 40;
  localparam int NVEC       = 28;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic       stsRd = 1'b0;
  logic       secPin = 1'b0;
  logic       fuse0Blown = 1'b0;
  logic       fuse1Blown = 1'b0;
  logic [7:0] stsData;
  logic       burnEn;
  logic [1:0] fuseSel;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_burn_seq #(.MAX_BURN_CYCLES(MAX_BURN)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stsRd(stsRd), .secPin(secPin), .fuse0Blown(fuse0Blown),
    .fuse1Blown(fuse1Blown), .stsData(stsData), .burnEn(burnEn), .fuseSel(fuseSel)
  );

  // {pin, addr, data, expBurn, expSel}
  localparam logic [13:0] VEC [0:NVEC-1] = '{
    {1'b1, 2'd2, 8'h54, 1'b0, 2'b00},  // R2 key
    {1'b1, 2'd2, 8'h81, 1'b0, 2'b01},  // R2 mode 0
    {1'b1, 2'd1, 8'hA6, 1'b1, 2'b01},  // R3 burn
    {1'b1, 2'd1, 8'h00, 1'b0, 2'b00},  // R3 stop
    {1'b1, 2'd2, 8'h54, 1'b0, 2'b00},
    {1'b1, 2'd2, 8'h82, 1'b0, 2'b10},  // R2 mode 1
    {1'b1, 2'd1, 8'hA6, 1'b1, 2'b10},
    {1'b1, 2'd1, 8'h00, 1'b0, 2'b00},
    {1'b0, 2'd2, 8'h54, 1'b0, 2'b00},
    {1'b0, 2'd2, 8'h81, 1'b0, 2'b01},  // R6 mode 0 ignores pin
    {1'b0, 2'd1, 8'hA6, 1'b1, 2'b01},
    {1'b0, 2'd1, 8'h00, 1'b0, 2'b00},
    {1'b1, 2'd1, 8'hA6, 1'b0, 2'b00},  // R4 trigger from idle
    {1'b1, 2'd2, 8'h54, 1'b0, 2'b00},
    {1'b1, 2'd1, 8'hA6, 1'b0, 2'b00},  // R4 trigger too early
    {1'b1, 2'd2, 8'h81, 1'b0, 2'b00},  // R4 key needed again
    {1'b1, 2'd2, 8'h54, 1'b0, 2'b00},
    {1'b1, 2'd2, 8'h55, 1'b0, 2'b00},  // R4 wrong code
    {1'b1, 2'd2, 8'h81, 1'b0, 2'b00},
    {1'b1, 2'd2, 8'h54, 1'b0, 2'b00},
    {1'b1, 2'd2, 8'h81, 1'b0, 2'b01},
    {1'b1, 2'd2, 8'h54, 1'b0, 2'b00},  // R4 fuse write after select
    {1'b1, 2'd1, 8'hA6, 1'b0, 2'b00},
    {1'b1, 2'd2, 8'h54, 1'b0, 2'b00},
    {1'b1, 2'd3, 8'hA6, 1'b0, 2'b00},  // R5 other address ignored
    {1'b1, 2'd2, 8'h81, 1'b0, 2'b01},  // R5 sequence intact
    {1'b1, 2'd1, 8'hA6, 1'b1, 2'b01},
    {1'b1, 2'd1, 8'h12, 1'b0, 2'b00}   // R4 nonzero trim during burn
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic pin, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk) secPin = pin;
    repeat (3) @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 burnEn", burnEn, 0);
    chk("R1 fuseSel", fuseSel, 0);
    chk("R1 err", stsData[7], 0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      doWrite(VEC[i][13], VEC[i][12:11], VEC[i][10:3]);
      chk($sformatf("R2/R3/R4/R5 vec%0d burnEn", i), burnEn, VEC[i][2]);
      chk($sformatf("R2/R3/R4/R5 vec%0d fuseSel", i), fuseSel, VEC[i][1:0]);
    end

    // R8 hardware limit
    doWrite(1'b1, 2'd2, 8'h54);
    doWrite(1'b1, 2'd2, 8'h81);
    doWrite(1'b1, 2'd1, 8'hA6);
    begin
      int n = 0;
      while (burnEn && n < 1000) begin n++; @(negedge clk); end
      chk("R8 burn length", n, MAX_BURN);
      chk("R8 fuseSel after limit", fuseSel, 0);
    end

    // R6 pin lost during mode-1 burn
    doWrite(1'b1, 2'd2, 8'h54);
    doWrite(1'b1, 2'd2, 8'h82);
    doWrite(1'b1, 2'd1, 8'hA6);
    chk("R6 mode1 burning", burnEn, 1);
    chk("R10 one-hot select", fuseSel, 2);
    secPin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 abort on pin low", burnEn, 0);
    chk("R6 select cleared", fuseSel, 0);

    // R7 mode-1 code with pin low
    doWrite(1'b0, 2'd2, 8'h54);
    doWrite(1'b0, 2'd2, 8'h82);
    chk("R7 no select", fuseSel, 0);
    chk("R7 err set", stsData[7], 1);
    doWrite(1'b0, 2'd2, 8'h81);
    chk("R4 key needed after error", fuseSel, 0);
    chk("R7 err sticky", stsData[7], 1);
    stsRd = 1'b1;
    @(negedge clk);
    stsRd = 1'b0;
    chk("R7 err cleared", stsData[7], 0);

    // R9 status bits
    fuse0Blown = 1'b1; fuse1Blown = 1'b0; secPin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 status pin+fuse0", stsData, 8'h22);
    fuse0Blown = 1'b0; fuse1Blown = 1'b1; secPin = 1'b0;
    @(negedge clk);
    chk("R9 pin synchroniser delay", stsData[5], 1);
    repeat (2) @(negedge clk);
    chk("R9 status fuse1", stsData, 8'h04);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule